// File: doc/BRIEF.md
# SD Card Host Data Path Sequencer

This block is the control state machine for the data side of an SD/SDIO host controller. A set of configuration inputs describes a transfer: block-size code, direction, block or stream mode, DMA enable, read-wait enable and a byte length. A start strobe launches the transfer. The sequencer then tracks progress against a byte-transfer strobe from the line serializer. That strobe stands in for the DAT lines. CRC, the serializer itself and clock generation live elsewhere.

On an accepted start the sequencer latches the direction, mode, DMA enable and decoded block size, and loads a down-counter with the length. It then chooses between read-wait, wait-receive and wait-send. Each transferred byte decrements the counter. In block mode a one-cycle pulse marks every completed block, and the machine drops back to its wait state between blocks. When the count reaches zero the machine returns to idle and raises a sticky end flag.

Top module: `sdio_data_seq`

## Requirements
- R1: After synchronous reset `state_o` is idle (code 0), `remaining` is 0 and `data_end`, `blk_end` and `dma_req` are low.
- R2: A block-size code c from 0 to 14 selects blocks of 2^c bytes. For example, code 2 gives 4 bytes, code 0 gives 1 byte and code 9 gives 512 bytes.
- R3: A start with block-size code 15 (reserved) is ignored. State, `remaining` and `data_end` keep their values, whether the sequencer is idle or busy.
- R4: An accepted start is taken in any state and restarts the transfer. With `rw_en`=1 the next state is read-wait (code 3). With `rw_en`=0 the next state is wait-receive (code 2) when `dir_rd`=1, or wait-send (code 1) when `dir_rd`=0.
- R5: On the clock edge of an accepted start, `remaining` loads `data_len`, and the position within the current block resets.
- R6: Each `xfer_strobe` in wait-send, wait-receive or transfer (code 4) decrements `remaining` by one and moves the machine to transfer. Strobes in idle or read-wait have no effect.
- R7: When `remaining` reaches 0 the machine goes to idle and `data_end` is set. `data_end` stays set until `clr_end` or the next accepted start.
- R8: In block mode (`stream_mode`=0), `blk_end` pulses for one cycle on the strobe that completes a block. Unless that strobe was the last byte, the machine then returns to the wait state for the latched direction.
- R9: In stream mode (`stream_mode`=1), `blk_end` never pulses.
- R10: Read-wait holds while `rw_en` is 1. In the cycle after `rw_en` is seen low, the machine moves to wait-receive.
- R11: An accepted start with `data_len`=0 leaves the machine idle, with `data_end` set.
- R12: `dma_req` equals the DMA enable latched at start while the machine is in wait-send, wait-receive or transfer. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| size_code | input | 4 | Block-size code, 2^code bytes, 15 reserved |
| dir_rd | input | 1 | 1 = card to host, 0 = host to card |
| stream_mode | input | 1 | 1 = stream/multibyte, 0 = block |
| dma_en | input | 1 | DMA enable, latched at start |
| rw_en | input | 1 | Read-wait enable |
| data_len | input | 25 | Transfer length in bytes |
| start | input | 1 | Start strobe |
| xfer_strobe | input | 1 | One byte moved by the serializer |
| clr_end | input | 1 | Clears the data-end flag |
| state_o | output | 3 | 0 idle, 1 wait-send, 2 wait-receive, 3 read-wait, 4 transfer |
| remaining | output | 25 | Bytes left |
| data_end | output | 1 | Sticky transfer-complete flag |
| blk_end | output | 1 | One-cycle block-complete pulse |
| dma_req | output | 1 | DMA service request |

## Verification
A wrong latch of direction or block size shows up one cycle after the block-completing strobe. It appears as the wrong wait-state code on `state_o`, or as a missing or misplaced `blk_end`. An off-by-one in the byte counter shows as a `remaining` value that differs from the programmed length minus the strobes seen, one edge after the first strobe. It also shifts the idle return and `data_end` by a cycle. Leaked strobes in idle or read-wait are caught at once through `remaining`, because the bench strobes in those states and then compares the count.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WSEND  = 3'd1,
    ST_WRECV  = 3'd2,
    ST_RDWAIT = 3'd3,
    ST_XFER   = 3'd4
  } seq_state_t;
endpackage

// File: rtl/sdseq_size_dec.sv
module sdseq_size_dec #(
  parameter int CODE_W = 4,
  localparam int SIZE_W = (2 ** CODE_W) - 1
) (
  input  logic [CODE_W-1:0] code,
  output logic [SIZE_W-1:0] size,
  output logic              valid
);
  // all-ones code is reserved, every other code is a power of two
  assign valid = (code != {CODE_W{1'b1}});
  assign size  = valid ? (SIZE_W'(1) << code) : '0;
endmodule

// File: rtl/sdseq_len_cnt.sv
module sdseq_len_cnt #(
  parameter int LEN_W = 25
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  input  logic             dec,
  output logic [LEN_W-1:0] cnt,
  output logic             last
);
  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= cnt - LEN_W'(1);
  end

  assign last = (cnt == LEN_W'(1));
endmodule

// File: rtl/sdseq_blk_cnt.sv
module sdseq_blk_cnt #(
  parameter int SIZE_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              inc,
  input  logic [SIZE_W-1:0] size,
  output logic              at_end
);
  logic [SIZE_W-1:0] pos;

  always_ff @(posedge clk) begin
    if (rst || clr) pos <= '0;
    else if (inc)   pos <= pos + SIZE_W'(1);
  end

  // true when the next byte completes the block
  assign at_end = ((pos + SIZE_W'(1)) == size);
endmodule

// File: rtl/sdio_data_seq.sv
module sdio_data_seq #(
  parameter int CODE_W = 4,
  parameter int LEN_W  = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] size_code,
  input  logic              dir_rd,
  input  logic              stream_mode,
  input  logic              dma_en,
  input  logic              rw_en,
  input  logic [LEN_W-1:0]  data_len,
  input  logic              start,
  input  logic              xfer_strobe,
  input  logic              clr_end,
  output logic [2:0]        state_o,
  output logic [LEN_W-1:0]  remaining,
  output logic              data_end,
  output logic              blk_end,
  output logic              dma_req
);
  import sdseq_pkg::*;

  localparam int SIZE_W = (2 ** CODE_W) - 1;

  seq_state_t        state, state_nx;
  logic              dir_q, mode_q, dma_q;
  logic [SIZE_W-1:0] size_q, size_dec;
  logic              size_ok, start_ok, len_zero;
  logic              active, accept, rem_last, blk_at_end, blk_hit, last_byte;

  sdseq_size_dec #(.CODE_W(CODE_W)) u_dec (
    .code  (size_code),
    .size  (size_dec),
    .valid (size_ok)
  );

  assign start_ok  = start && size_ok;
  assign len_zero  = (data_len == '0);
  assign active    = (state == ST_WSEND) || (state == ST_WRECV) || (state == ST_XFER);
  assign accept    = xfer_strobe && active && !start_ok;
  assign last_byte = accept && rem_last;
  assign blk_hit   = accept && !mode_q && blk_at_end;

  sdseq_len_cnt #(.LEN_W(LEN_W)) u_len (
    .clk      (clk),
    .rst      (rst),
    .load     (start_ok),
    .load_val (data_len),
    .dec      (accept),
    .cnt      (remaining),
    .last     (rem_last)
  );

  sdseq_blk_cnt #(.SIZE_W(SIZE_W)) u_blk (
    .clk    (clk),
    .rst    (rst),
    .clr    (start_ok || (accept && (blk_at_end || rem_last))),
    .inc    (accept),
    .size   (size_q),
    .at_end (blk_at_end)
  );

  always_comb begin
    state_nx = state;
    if (start_ok) begin
      if (len_zero)    state_nx = ST_IDLE;
      else if (rw_en)  state_nx = ST_RDWAIT;
      else if (dir_rd) state_nx = ST_WRECV;
      else             state_nx = ST_WSEND;
    end else begin
      unique case (state)
        ST_RDWAIT: if (!rw_en) state_nx = ST_WRECV;
        ST_WSEND, ST_WRECV, ST_XFER: begin
          if (accept) begin
            if (rem_last)     state_nx = ST_IDLE;
            else if (blk_hit) state_nx = dir_q ? ST_WRECV : ST_WSEND;
            else              state_nx = ST_XFER;
          end
        end
        default: state_nx = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      dir_q    <= 1'b0;
      mode_q   <= 1'b0;
      dma_q    <= 1'b0;
      size_q   <= '0;
      data_end <= 1'b0;
      blk_end  <= 1'b0;
    end else begin
      state   <= state_nx;
      blk_end <= blk_hit;
      if (start_ok) begin
        dir_q  <= dir_rd || rw_en;
        mode_q <= stream_mode;
        dma_q  <= dma_en;
        size_q <= size_dec;
      end
      if (start_ok)       data_end <= len_zero;
      else if (last_byte) data_end <= 1'b1;
      else if (clr_end)   data_end <= 1'b0;
    end
  end

  assign state_o = state;
  assign dma_req = dma_q && active;
endmodule

// File: rtl/sdseq_chk.sv
module sdseq_chk #(
  parameter int CODE_W = 4,
  parameter int LEN_W  = 25
) (
  input logic              clk,
  input logic              rst,
  input logic [CODE_W-1:0] size_code,
  input logic              start,
  input logic              rw_en,
  input logic              xfer_strobe,
  input logic [2:0]        state_o,
  input logic [LEN_W-1:0]  remaining,
  input logic              data_end,
  input logic              blk_end,
  input logic              dma_req,
  input logic              mode_q
);
  import sdseq_pkg::*;

  logic act;
  assign act = (state_o == ST_WSEND) || (state_o == ST_WRECV) || (state_o == ST_XFER);

  // R6: an accepted byte lowers the count by exactly one
  a_r6_decrement: assert property (@(posedge clk) disable iff (rst)
    (xfer_strobe && act && !start) |=> (remaining == $past(remaining) - LEN_W'(1)));

  // R6: idle without a start leaves the count alone
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_IDLE && !start) |=> $stable(remaining));

  // R3: reserved code start while idle changes nothing
  a_r3_reserved: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_IDLE && start && size_code == {CODE_W{1'b1}}) |=> (state_o == ST_IDLE && $stable(remaining)));

  // R7: the end flag only appears together with idle
  a_r7_end_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(data_end) |-> (state_o == ST_IDLE));

  // R9: no block pulse in stream mode
  a_r9_no_pulse: assert property (@(posedge clk) disable iff (rst)
    blk_end |-> !$past(mode_q));

  // R10: read-wait holds while enabled
  a_r10_rw_hold: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_RDWAIT && rw_en && !start) |=> (state_o == ST_RDWAIT));

  // R12: DMA request only in the data-moving states
  a_r12_dma_state: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> act);
endmodule

bind sdio_data_seq sdseq_chk #(.CODE_W(CODE_W), .LEN_W(LEN_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .size_code   (size_code),
  .start       (start),
  .rw_en       (rw_en),
  .xfer_strobe (xfer_strobe),
  .state_o     (state_o),
  .remaining   (remaining),
  .data_end    (data_end),
  .blk_end     (blk_end),
  .dma_req     (dma_req),
  .mode_q      (mode_q)
);

// File: tb/test_sdio_data_seq.sv
`timescale 1ns/1ps
module test_sdio_data_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  size_code = 4'd2;
  logic        dir_rd = 1'b0, stream_mode = 1'b0, dma_en = 1'b0, rw_en = 1'b0;
  logic [24:0] data_len = '0;
  logic        start = 1'b0, xfer_strobe = 1'b0, clr_end = 1'b0;
  logic [2:0]  state_o;
  logic [24:0] remaining;
  logic        data_end, blk_end, dma_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [2:0]  st;
    logic [24:0] rem;
    logic        de;
    logic        be;
    logic        dma;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  sdio_data_seq i_sdio_data_seq (
    .clk(clk), .rst(rst), .size_code(size_code), .dir_rd(dir_rd),
    .stream_mode(stream_mode), .dma_en(dma_en), .rw_en(rw_en),
    .data_len(data_len), .start(start), .xfer_strobe(xfer_strobe),
    .clr_end(clr_end), .state_o(state_o), .remaining(remaining),
    .data_end(data_end), .blk_end(blk_end), .dma_req(dma_req)
  );

  // monitor: pops one expectation per clock edge and compares
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (state_o !== e.st || remaining !== e.rem || data_end !== e.de ||
            blk_end !== e.be || dma_req !== e.dma) begin
          fails++;
          $display("FAIL %s: got st=%0d rem=%0d de=%b be=%b dma=%b exp st=%0d rem=%0d de=%b be=%b dma=%b",
                   e.tag, state_o, remaining, data_end, blk_end, dma_req,
                   e.st, e.rem, e.de, e.be, e.dma);
        end
      end
    end
  end

  // driver: inputs already set at a falling edge; queue the result of the next rising edge
  task automatic step(input logic [2:0] st, input int rem, input bit de, input bit be,
                      input bit dma, input string tag);
    exp_t e;
    e.st = st; e.rem = rem[24:0]; e.de = de; e.be = be; e.dma = dma; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    start = 1'b0; xfer_strobe = 1'b0; clr_end = 1'b0;
  endtask

  task automatic launch(input logic [3:0] code, input int len, input bit dir,
                        input bit strm, input bit dma, input bit rw);
    size_code = code; data_len = len[24:0]; dir_rd = dir;
    stream_mode = strm; dma_en = dma; rw_en = rw; start = 1'b1;
  endtask

  // bytes first..last of a transfer with the given block size (R2, R6, R7, R8, R9, R12)
  task automatic run_bytes(input int len, input int bsize, input bit strm, input bit dir,
                           input bit dma, input int first, input int last, input string tag);
    for (int i = first; i <= last; i++) begin
      int rem;
      bit be;
      logic [2:0] st;
      rem = len - i;
      be  = !strm && (i % bsize == 0);
      st  = (rem == 0) ? 3'd0 : (be ? (dir ? 3'd2 : 3'd1) : 3'd4);
      xfer_strobe = 1'b1;
      step(st, rem, rem == 0, be, dma && rem != 0, tag);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    step(3'd0, 0, 0, 0, 0, "R1 reset state");

    // block-mode write, 4-byte blocks, 10 bytes
    launch(4'd2, 10, 1'b0, 1'b0, 1'b1, 1'b0);
    step(3'd1, 10, 0, 0, 1, "R4 R5 write start");
    run_bytes(10, 4, 1'b0, 1'b0, 1'b1, 1, 10, "R2 R6 R8 block write");
    step(3'd0, 0, 1, 0, 0, "R7 end flag held");
    xfer_strobe = 1'b1;
    step(3'd0, 0, 1, 0, 0, "R6 strobe in idle ignored");
    clr_end = 1'b1;
    step(3'd0, 0, 0, 0, 0, "R7 clear strobe");

    // stream read
    launch(4'd2, 5, 1'b1, 1'b1, 1'b0, 1'b0);
    step(3'd2, 5, 0, 0, 0, "R4 read start");
    run_bytes(5, 4, 1'b1, 1'b1, 1'b0, 1, 5, "R9 stream no block pulse");

    // zero length
    launch(4'd2, 0, 1'b0, 1'b0, 1'b0, 1'b0);
    step(3'd0, 0, 1, 0, 0, "R11 zero length");

    // reserved code while idle
    launch(4'd15, 7, 1'b0, 1'b0, 1'b0, 1'b0);
    step(3'd0, 0, 1, 0, 0, "R3 reserved idle");

    // read-wait path, start also clears the end flag
    launch(4'd2, 5, 1'b0, 1'b0, 1'b1, 1'b1);
    step(3'd3, 5, 0, 0, 0, "R4 R7 read-wait start");
    xfer_strobe = 1'b1;
    step(3'd3, 5, 0, 0, 0, "R6 R10 strobe in read-wait");
    rw_en = 1'b0;
    step(3'd2, 5, 0, 0, 1, "R10 leave read-wait");
    xfer_strobe = 1'b1;
    step(3'd4, 4, 0, 0, 1, "R6 first byte after read-wait");

    // restart mid-transfer, then reserved start while busy
    launch(4'd2, 6, 1'b0, 1'b0, 1'b1, 1'b0);
    step(3'd1, 6, 0, 0, 1, "R4 R5 restart");
    run_bytes(6, 4, 1'b0, 1'b0, 1'b1, 1, 4, "R5 R8 after restart");
    launch(4'd15, 99, 1'b1, 1'b1, 1'b0, 1'b0);
    step(3'd1, 2, 0, 0, 1, "R3 reserved while busy");
    size_code = 4'd2;
    run_bytes(6, 4, 1'b0, 1'b0, 1'b1, 5, 6, "R7 R8 partial last block");

    // 512-byte blocks, read
    launch(4'd9, 1024, 1'b1, 1'b0, 1'b0, 1'b0);
    step(3'd2, 1024, 0, 0, 0, "R2 R7 large block start");
    run_bytes(1024, 512, 1'b0, 1'b1, 1'b0, 1, 1024, "R2 R8 512-byte blocks");

    // 1-byte blocks
    launch(4'd0, 3, 1'b0, 1'b0, 1'b0, 1'b0);
    step(3'd1, 3, 0, 0, 0, "R2 R7 single-byte block start");
    run_bytes(3, 1, 1'b0, 1'b0, 1'b0, 1, 3, "R2 R8 single-byte blocks");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule